// File: doc/BRIEF.md
# Destination Rename Map with Register Pinning

This block renames architectural destination registers to physical registers. For each accepted request it reads the current mapping of the architectural index and picks one of three outcomes. A request for the hard-wired zero register keeps its permanent mapping. A destination whose current physical register still has pinned writes outstanding keeps that same physical register and uses up one pinned write. Any other destination takes a fresh physical register from an external free list. In that case the map entry is updated and the new register's counters are loaded from the request.

Every accepted rename returns the new tag and the tag it replaces. It also returns the register's pinned-writes-left and writes-to-complete counts after the operation. A scoreboard clear is issued for the new tag at the same time. The free list is a separate block: it presents its head tag with a valid flag, and this block pops it with a one-cycle strobe. One rename is accepted per cycle under a valid/ready handshake. When an allocation is needed and the free list is empty, the request is held off.

Top module: `pin_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, all pinned-writes-left and writes-to-complete counts are zero, and rsp_valid is low.
- R2: A request for architectural index 0 returns new tag 0 and previous tag 0, reports both counts as zero, does not pop the free list and changes no map entry.
- R3: When the current mapping has no pinned writes left, an accepted non-zero request pops the free list in the accept cycle (fl_pop high). It returns the free-list head as the new tag and the old mapping as the previous tag, and later requests for that index see the new tag.
- R4: On a fresh allocation with requested count n, the reported pinned-writes-left is n and the reported writes-to-complete is n+1. Both are stored for the new tag.
- R5: When the current mapping has a pinned-writes-left count above zero, the request returns that same tag as both new and previous tag, with rsp_reused high. It pops nothing and reports the count decremented by one.
- R6: A request that reuses a pinned register while carrying a non-zero requested count sets rsp_err. The request is still handled as a reuse, and its requested count has no effect on the stored counts.
- R7: When an allocation is needed and fl_valid is low, req_ready is low, fl_pop stays low and the map is unchanged. Zero-register and reuse requests are accepted regardless of fl_valid.
- R8: The response appears exactly one cycle after acceptance, with rsp_valid high for one cycle per accepted request.
- R9: sb_clr_valid and sb_clr_tag pulse together with the response and carry the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rename request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_arch | input | 5 | Architectural destination index |
| req_pins | input | 3 | Requested pinned-write count |
| fl_valid | input | 1 | Free list has a register available |
| fl_tag | input | 6 | Free-list head tag |
| fl_pop | output | 1 | Consume the free-list head (accept cycle) |
| rsp_valid | output | 1 | Rename result valid |
| rsp_new_tag | output | 6 | Physical tag now mapped |
| rsp_prev_tag | output | 6 | Physical tag mapped before the rename |
| rsp_reused | output | 1 | Pinned register was reused |
| rsp_err | output | 1 | Reuse request carried a non-zero pin count |
| rsp_pin_left | output | 3 | Pinned writes left on the new tag |
| rsp_wtc | output | 4 | Writes-to-complete count of the new tag |
| sb_clr_valid | output | 1 | Scoreboard not-ready strobe |
| sb_clr_tag | output | 6 | Tag whose ready bit is cleared |

## Verification
Each path is tried on its own: zero-register requests, plain allocations with a zero pin count, and allocations with pin counts of 1 and 2. The pinned allocations are followed by reuse chains that run the count down to zero and then fall back to a fresh pop. Together these separate a design that always allocates from one that reuses too long or too briefly. A reuse request with a non-zero count tells an erroring-but-correct reuse apart from one that reloads the counts. Draining the free list, then requesting an allocation and a reuse, shows that only the allocation stalls. The prev tag of the later response shows that the stalled request left the map unchanged.

// File: rtl/pin_rename_pkg.sv
package pin_rename_pkg;
  parameter int ARCH_REGS = 32;
  parameter int PHYS_REGS = 64;
  parameter int PIN_BITS  = 3;

  localparam int AW  = $clog2(ARCH_REGS);
  localparam int TW  = $clog2(PHYS_REGS);
  localparam int CW  = PIN_BITS + 1;

  typedef logic [AW-1:0]       arch_t;
  typedef logic [TW-1:0]       tag_t;
  typedef logic [PIN_BITS-1:0] pin_t;
  typedef logic [CW-1:0]       wtc_t;

  typedef struct packed {
    pin_t left;
    wtc_t wtc;
  } pin_rec_t;

  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_REUSE = 2'd1,
    OP_ALLOC = 2'd2
  } op_t;
endpackage

// File: rtl/prm_map_table.sv
module prm_map_table
  import pin_rename_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  arch_t rd_idx,
  output tag_t  rd_tag,
  input  logic  wr_en,
  input  arch_t wr_idx,
  input  tag_t  wr_tag
);
  // Entry 0 is the zero register: not stored, always reads physical 0.
  tag_t ent [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) ent[i] <= tag_t'(i);
    end else if (wr_en && wr_idx != '0) begin
      ent[wr_idx] <= wr_tag;
    end
  end

  always_comb begin
    rd_tag = (rd_idx == '0) ? '0 : ent[rd_idx];
  end
endmodule

// File: rtl/prm_pin_table.sv
module prm_pin_table
  import pin_rename_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tag_t     rd_tag,
  output pin_rec_t rd_rec,
  input  logic     wr_en,
  input  tag_t     wr_tag,
  input  pin_rec_t wr_rec
);
  pin_rec_t rec [PHYS_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_REGS; i++) rec[i] <= '0;
    end else if (wr_en) begin
      rec[wr_tag] <= wr_rec;
    end
  end

  assign rd_rec = rec[rd_tag];
endmodule

// File: rtl/prm_ctrl.sv
module prm_ctrl
  import pin_rename_pkg::*;
(
  input  logic     req_valid,
  input  arch_t    req_arch,
  input  pin_t     req_pins,
  input  pin_rec_t cur_rec,
  input  logic     fl_valid,
  output logic     req_ready,
  output logic     accept,
  output op_t      op,
  output logic     err
);
  always_comb begin
    if (req_arch == '0)             op = OP_ZERO;
    else if (cur_rec.left != '0)    op = OP_REUSE;
    else                            op = OP_ALLOC;
    req_ready = (op != OP_ALLOC) || fl_valid;
    accept    = req_valid && req_ready;
    err       = (op == OP_REUSE) && (req_pins != '0);
  end
endmodule

// File: rtl/pin_rename_map.sv
module pin_rename_map
  import pin_rename_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_arch,
  input  logic [PIN_BITS-1:0] req_pins,
  input  logic                fl_valid,
  input  logic [TW-1:0]       fl_tag,
  output logic                fl_pop,
  output logic                rsp_valid,
  output logic [TW-1:0]       rsp_new_tag,
  output logic [TW-1:0]       rsp_prev_tag,
  output logic                rsp_reused,
  output logic                rsp_err,
  output logic [PIN_BITS-1:0] rsp_pin_left,
  output logic [CW-1:0]       rsp_wtc,
  output logic                sb_clr_valid,
  output logic [TW-1:0]       sb_clr_tag
);
  tag_t     cur_tag;
  pin_rec_t cur_rec;
  logic     accept;
  logic     err;
  op_t      op;

  tag_t     new_tag;
  pin_rec_t new_rec;
  logic     map_we;
  logic     pin_we;

  prm_map_table u_map (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (req_arch),
    .rd_tag (cur_tag),
    .wr_en  (map_we),
    .wr_idx (req_arch),
    .wr_tag (fl_tag)
  );

  prm_pin_table u_pins (
    .clk    (clk),
    .rst    (rst),
    .rd_tag (cur_tag),
    .rd_rec (cur_rec),
    .wr_en  (pin_we),
    .wr_tag (new_tag),
    .wr_rec (new_rec)
  );

  prm_ctrl u_ctrl (
    .req_valid (req_valid),
    .req_arch  (req_arch),
    .req_pins  (req_pins),
    .cur_rec   (cur_rec),
    .fl_valid  (fl_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .op        (op),
    .err       (err)
  );

  always_comb begin
    new_tag = cur_tag;
    new_rec = cur_rec;
    map_we  = 1'b0;
    pin_we  = 1'b0;
    unique case (op)
      OP_ZERO: begin
        new_tag = '0;
        new_rec = '0;
      end
      OP_REUSE: begin
        new_rec.left = cur_rec.left - pin_t'(1);
        pin_we       = accept;
      end
      default: begin
        new_tag      = fl_tag;
        new_rec.left = req_pins;
        new_rec.wtc  = wtc_t'(req_pins) + wtc_t'(1);
        map_we       = accept;
        pin_we       = accept;
      end
    endcase
    fl_pop = accept && (op == OP_ALLOC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_new_tag  <= '0;
      rsp_prev_tag <= '0;
      rsp_reused   <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_pin_left <= '0;
      rsp_wtc      <= '0;
      sb_clr_valid <= 1'b0;
      sb_clr_tag   <= '0;
    end else begin
      rsp_valid    <= accept;
      sb_clr_valid <= accept;
      if (accept) begin
        rsp_new_tag  <= new_tag;
        rsp_prev_tag <= cur_tag;
        rsp_reused   <= (op == OP_REUSE);
        rsp_err      <= err;
        rsp_pin_left <= new_rec.left;
        rsp_wtc      <= new_rec.wtc;
        sb_clr_tag   <= new_tag;
      end
    end
  end

  // R7
  pop_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
    fl_pop |-> fl_valid);

  // R3
  pop_only_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    fl_pop |-> (req_valid && req_ready));

  // R8
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R5
  reuse_same_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_reused) |-> (rsp_new_tag == rsp_prev_tag));

  // R6
  err_only_on_reuse_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> rsp_reused);

  // R9
  sb_follows_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    sb_clr_valid |-> (rsp_valid && sb_clr_tag == rsp_new_tag));
endmodule

// File: tb/tb_pin_rename_map.sv
module tb_pin_rename_map;
  import pin_rename_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic req_valid = 1'b0;
  logic req_ready;
  arch_t req_arch = '0;
  pin_t  req_pins = '0;
  logic  fl_valid;
  tag_t  fl_tag;
  logic  fl_pop;
  logic  rsp_valid, rsp_reused, rsp_err, sb_clr_valid;
  tag_t  rsp_new_tag, rsp_prev_tag, sb_clr_tag;
  pin_t  rsp_pin_left;
  wtc_t  rsp_wtc;

  pin_rename_map dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_arch(req_arch), .req_pins(req_pins),
    .fl_valid(fl_valid), .fl_tag(fl_tag), .fl_pop(fl_pop),
    .rsp_valid(rsp_valid), .rsp_new_tag(rsp_new_tag), .rsp_prev_tag(rsp_prev_tag),
    .rsp_reused(rsp_reused), .rsp_err(rsp_err),
    .rsp_pin_left(rsp_pin_left), .rsp_wtc(rsp_wtc),
    .sb_clr_valid(sb_clr_valid), .sb_clr_tag(sb_clr_tag)
  );

  typedef struct {
    tag_t nt; tag_t pt; logic ru; logic er; pin_t pl; wtc_t wc; string rq;
  } exp_t;

  exp_t exp_q[$];
  tag_t fl_q[$];
  tag_t m_map [ARCH_REGS];
  pin_t m_left [PHYS_REGS];
  wtc_t m_wtc [PHYS_REGS];

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  assign fl_valid = (fl_q.size() > 0);
  assign fl_tag   = (fl_q.size() > 0) ? fl_q[0] : '0;

  task automatic chk(input string rq, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // Driver: compute expectation from the model, then perform one handshake.
  task automatic rename(input int a, input int p, input string rq);
    exp_t e;
    int   cur;
    logic alloc;
    cur   = (a == 0) ? 0 : m_map[a];
    e.rq  = rq;
    e.pt  = tag_t'(cur);
    e.er  = 1'b0;
    e.ru  = 1'b0;
    alloc = 1'b0;
    if (a == 0) begin
      e.nt = '0; e.pl = '0; e.wc = '0;
    end else if (m_left[cur] != 0) begin
      e.ru = 1'b1;
      e.er = (p != 0);
      m_left[cur] = m_left[cur] - 1'b1;
      e.nt = tag_t'(cur); e.pl = m_left[cur]; e.wc = m_wtc[cur];
    end else begin
      alloc = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_arch  = arch_t'(a);
    req_pins  = pin_t'(p);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (alloc) begin
      e.nt = fl_q[0];
      e.pl = pin_t'(p);
      e.wc = wtc_t'(p) + wtc_t'(1);
      m_map[a] = e.nt;
      m_left[e.nt] = e.pl;
      m_wtc[e.nt] = e.wc;
    end
    chk({rq, " fl_pop"}, fl_pop == alloc, fl_pop, alloc);
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    if (alloc) void'(fl_q.pop_front());
    req_valid = 1'b0;
  endtask

  // Monitor: compare responses as they appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        chk("R8 unexpected response", 1'b0, 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk({e.rq, " new_tag"},  rsp_new_tag  == e.nt, rsp_new_tag, e.nt);
        chk({e.rq, " prev_tag"}, rsp_prev_tag == e.pt, rsp_prev_tag, e.pt);
        chk({e.rq, " reused"},   rsp_reused   == e.ru, rsp_reused, e.ru);
        chk({e.rq, " err R6"},   rsp_err      == e.er, rsp_err, e.er);
        chk({e.rq, " pin_left"}, rsp_pin_left == e.pl, rsp_pin_left, e.pl);
        chk({e.rq, " wtc"},      rsp_wtc      == e.wc, rsp_wtc, e.wc);
        chk("R9 sb_clr_valid", sb_clr_valid == 1'b1, sb_clr_valid, 1);
        chk("R9 sb_clr_tag", sb_clr_tag == e.nt, sb_clr_tag, e.nt);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk("watchdog", 1'b0, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ARCH_REGS; i++) m_map[i] = tag_t'(i);
    for (int i = 0; i < PHYS_REGS; i++) begin m_left[i] = '0; m_wtc[i] = '0; end
    for (int i = ARCH_REGS; i < PHYS_REGS; i++) fl_q.push_back(tag_t'(i));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", rsp_valid == 1'b0, rsp_valid, 0);
    chk("R1 req_ready", req_ready == 1'b1, req_ready, 1);
    rename(5, 0, "R1 reset mapping");
    rename(0, 0, "R2 zero reg");
    rename(0, 4, "R2 zero reg pinned req");
    rename(3, 0, "R3 alloc");
    rename(3, 0, "R3 realloc sees new map");
    rename(7, 2, "R4 pinned alloc");
    rename(7, 0, "R5 reuse 1");
    rename(7, 0, "R5 reuse 2");
    rename(7, 0, "R3 alloc after pins used");
    rename(9, 1, "R4 pin one");
    rename(9, 3, "R6 double pin");
    rename(9, 0, "R6 count ignored alloc");
    rename(31, 7, "R4 max pins");
    // R8: response lasts one cycle
    @(negedge clk);
    chk("R8 single pulse", rsp_valid == 1'b0, rsp_valid, 0);
    // R7: drain free list, then stall
    while (fl_q.size() > 0) void'(fl_q.pop_front());
    rename(31, 0, "R7 reuse while empty");
    @(negedge clk);
    req_valid = 1'b1; req_arch = arch_t'(12); req_pins = '0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R7 ready low", req_ready == 1'b0, req_ready, 0);
      chk("R7 no pop", fl_pop == 1'b0, fl_pop, 0);
      @(negedge clk);
      chk("R7 no response", rsp_valid == 1'b0, rsp_valid, 0);
    end
    req_valid = 1'b0;
    fl_q.push_back(tag_t'(40));
    rename(12, 0, "R7 map unchanged after stall");
    rename(0, 0, "R2 zero after traffic");
    repeat (3) @(negedge clk);
    chk("R8 all responses seen", exp_q.size() == 0, exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule